// File: doc/BRIEF.md
# NAND Page Parity Code Generator and Checker

This block computes line-and-column parity codes over the byte stream of one NAND page. It runs two separate accumulators. The main accumulator covers the data part of the page. The spare accumulator covers the bytes in the spare area that hold the stored main code. Each accumulator folds in bytes only while its region is unlocked. When its lock rises, its current code is copied into a result register that the code output shows.

When a page is written, software streams the data with the main region unlocked, then locks it and writes the code into the spare area. It then unlocks the spare region, streams the four code bytes, locks it, and stores the spare code behind them. The layout in the spare area is fixed: bytes 0 to 3 hold the main code, least significant byte first, and bytes 4 and 5 hold the spare code.

When a page is read back, the same passes run. The stored codes are then loaded into reference registers. The syndrome is the XOR of each reference with the freshly computed code. From the syndrome, a 4-bit status is reported together with the location of any single-bit error. Bits 1:0 of the status cover the main region and bits 3:2 cover the spare region.

The byte input is a valid/ready stream. A byte is taken in every cycle where `in_valid` and `in_ready` are both high. The block applies back-pressure only while `ecc_clear` is high. A producer that holds `in_valid` through that cycle simply has its byte taken in the next cycle.

Top module: `nand_page_ecc`

## Requirements
- R1: While `ecc_clear` is high, both accumulators and both byte offsets return to zero and both reference-valid flags drop. After `ecc_clear` is released, `err_status` reads 0000. The code outputs keep their last latched values.
- R2: `in_ready` is low only in cycles where `ecc_clear` is high. A byte is accepted exactly when `in_valid` and `in_ready` are both high.
- R3: An accepted byte is folded into an accumulator only while that region's lock is low. Each folded byte advances that region's offset by one. Bytes taken while the region is locked change neither its code nor its offsets.
- R4: In the cycle a lock input rises, the accumulator's value is copied to its code output (`main_code` or `spare_code`). The output then holds that value for as long as the lock stays high.
- R5: Code layout, with N the region size and A = log2(N):
  - Bit 2k is the parity of every data bit in bytes whose offset has bit k clear. Bit 2k+1 covers bytes whose offset has bit k set, for k < A.
  - Bit 2A+2j is the parity of data bit positions whose index has bit j clear. Bit 2A+2j+1 covers positions whose index has bit j set, for j < 3.
  - The remaining bits up to a whole number of bytes are zero.
- R6: The spare code uses the same scheme over its first SPARE_BYTES (4) folded bytes. Either accumulator ignores bytes beyond its region size.
- R7: `main_ref_load` and `spare_ref_load` capture the stored codes. A region's status is 00 until a reference has been loaded for it since the last clear. After that, its status reflects the syndrome between the reference and the latched code. Status codes: 00 = clean, 01 = correctable single-bit error, 10 = uncorrectable, 11 = error within the stored code.
- R8: A region reports 01 when every bit pair (2i, 2i+1) of its syndrome differs and its pad bits are zero. It then reports the erroneous byte offset and bit index, taken from the odd syndrome bits. At any other status, the location outputs are zero.
- R9: A nonzero syndrome that is not correctable gives 11 when exactly one syndrome bit is set. Otherwise it gives 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ecc_clear | input | 1 | Clears accumulators, offsets and reference-valid flags |
| main_lock | input | 1 | High locks the main accumulator; a rising edge latches its code |
| spare_lock | input | 1 | High locks the spare accumulator; a rising edge latches its code |
| in_valid | input | 1 | Byte stream valid |
| in_ready | output | 1 | Byte stream ready |
| in_data | input | 8 | Byte stream data |
| main_code | output | MAIN_CW (32) | Latched main-area code |
| spare_code | output | SPARE_CW (16) | Latched spare-area code |
| main_ref_load | input | 1 | Captures `main_ref` |
| main_ref | input | MAIN_CW (32) | Stored main code read from the page |
| spare_ref_load | input | 1 | Captures `spare_ref` |
| spare_ref | input | SPARE_CW (16) | Stored spare code read from the page |
| err_status | output | 4 | Bits 3:2 are the spare status; bits 1:0 are the main status |
| main_err_byte | output | MAIN_AW (11) | Byte offset of a correctable main error |
| main_err_bit | output | 3 | Bit index of a correctable main error |
| spare_err_byte | output | SPARE_AW (2) | Byte offset of a correctable spare error |
| spare_err_bit | output | 3 | Bit index of a correctable spare error |

## Verification
The freeze properties assume that a lock input, once raised, is held for whole cycles. The status-after-clear property assumes that no reference load is expected to survive a clear in the same cycle.

The bench changes every lock, clear and load at the falling clock edge and keeps each of them stable for at least one full cycle. It loads references only after both locks have latched. Across the sweeps, the data stream is the only input that changes during an unlocked window.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

  typedef enum logic [1:0] {
    ST_CLEAN = 2'b00,
    ST_FIX   = 2'b01,
    ST_MULTI = 2'b10,
    ST_CODE  = 2'b11
  } ecc_stat_e;

  // width of a code for an offset of aw bits, rounded up to whole bytes
  function automatic int code_bits(input int aw);
    return ((2 * aw + 6 + 7) / 8) * 8;
  endfunction

  // bit positions within a byte whose index has bit j set
  function automatic logic [7:0] col_mask(input int j);
    case (j)
      0:       return 8'hAA;
      1:       return 8'hCC;
      default: return 8'hF0;
    endcase
  endfunction

endpackage

// File: rtl/ecc_accum.sv
module ecc_accum
  import nand_ecc_pkg::*;
#(
  parameter int N  = 2048,
  parameter int AW = $clog2(N),
  parameter int CW = code_bits(AW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          lock,
  input  logic          beat,
  input  logic [7:0]    data,
  output logic [CW-1:0] code
);

  logic [CW-1:0] acc;
  logic [CW-1:0] acc_nx;
  logic [AW:0]   cnt;
  logic          lock_q;
  logic          fold;
  logic          par;

  // fold only while unlocked and inside the region
  assign fold = beat && !lock && (int'(cnt) < N);

  always_comb begin
    acc_nx = acc;
    par    = ^data;
    for (int k = 0; k < AW; k++) begin
      if (cnt[k]) acc_nx[2*k+1] = acc_nx[2*k+1] ^ par;
      else        acc_nx[2*k]   = acc_nx[2*k]   ^ par;
    end
    for (int j = 0; j < 3; j++) begin
      acc_nx[2*AW+2*j+1] = acc_nx[2*AW+2*j+1] ^ (^(data & col_mask(j)));
      acc_nx[2*AW+2*j]   = acc_nx[2*AW+2*j]   ^ (^(data & ~col_mask(j)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc    <= '0;
      cnt    <= '0;
      lock_q <= 1'b1;
      code   <= '0;
    end else begin
      lock_q <= lock;
      if (clear) begin
        acc <= '0;
        cnt <= '0;
      end else if (fold) begin
        acc <= acc_nx;
        cnt <= cnt + 1'b1;
      end
      if (lock && !lock_q) code <= acc;
    end
  end

endmodule

// File: rtl/ecc_syndrome.sv
module ecc_syndrome
  import nand_ecc_pkg::*;
#(
  parameter int AW = 11,
  parameter int CW = code_bits(AW)
) (
  input  logic          chk,
  input  logic [CW-1:0] syn,
  output logic [1:0]    stat,
  output logic [AW-1:0] loc_byte,
  output logic [2:0]    loc_bit
);

  localparam int PAIRS = AW + 3;

  logic pairs_split;
  logic pad_clear;
  logic one_hot;
  ecc_stat_e st;

  always_comb begin
    pairs_split = 1'b1;
    for (int p = 0; p < PAIRS; p++)
      if (syn[2*p] == syn[2*p+1]) pairs_split = 1'b0;
    pad_clear = 1'b1;
    for (int i = 2 * PAIRS; i < CW; i++)
      if (syn[i]) pad_clear = 1'b0;
    one_hot = ($countones(syn) == 1);

    if (!chk || syn == '0)          st = ST_CLEAN;
    else if (pairs_split && pad_clear) st = ST_FIX;
    else if (one_hot)               st = ST_CODE;
    else                            st = ST_MULTI;

    loc_byte = '0;
    loc_bit  = '0;
    if (st == ST_FIX) begin
      for (int k = 0; k < AW; k++) loc_byte[k] = syn[2*k+1];
      for (int j = 0; j < 3; j++)  loc_bit[j]  = syn[2*AW+2*j+1];
    end
  end

  assign stat = st;

endmodule

// File: rtl/nand_page_ecc.sv
module nand_page_ecc
  import nand_ecc_pkg::*;
#(
  parameter int   MAIN_BYTES  = 2048,
  parameter int   SPARE_BYTES = 4,
  localparam int  MAIN_AW     = $clog2(MAIN_BYTES),
  localparam int  SPARE_AW    = $clog2(SPARE_BYTES),
  localparam int  MAIN_CW     = code_bits(MAIN_AW),
  localparam int  SPARE_CW    = code_bits(SPARE_AW)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ecc_clear,
  input  logic                main_lock,
  input  logic                spare_lock,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [7:0]          in_data,
  output logic [MAIN_CW-1:0]  main_code,
  output logic [SPARE_CW-1:0] spare_code,
  input  logic                main_ref_load,
  input  logic [MAIN_CW-1:0]  main_ref,
  input  logic                spare_ref_load,
  input  logic [SPARE_CW-1:0] spare_ref,
  output logic [3:0]          err_status,
  output logic [MAIN_AW-1:0]  main_err_byte,
  output logic [2:0]          main_err_bit,
  output logic [SPARE_AW-1:0] spare_err_byte,
  output logic [2:0]          spare_err_bit
);

  logic                beat;
  logic [MAIN_CW-1:0]  main_ref_q;
  logic [SPARE_CW-1:0] spare_ref_q;
  logic                main_chk;
  logic                spare_chk;
  logic [1:0]          main_stat;
  logic [1:0]          spare_stat;

  assign in_ready = !ecc_clear;
  assign beat     = in_valid && in_ready;

  ecc_accum #(.N(MAIN_BYTES), .AW(MAIN_AW), .CW(MAIN_CW)) u_main (
    .clk(clk), .rst_n(rst_n), .clear(ecc_clear), .lock(main_lock),
    .beat(beat), .data(in_data), .code(main_code)
  );

  ecc_accum #(.N(SPARE_BYTES), .AW(SPARE_AW), .CW(SPARE_CW)) u_spare (
    .clk(clk), .rst_n(rst_n), .clear(ecc_clear), .lock(spare_lock),
    .beat(beat), .data(in_data), .code(spare_code)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_ref_q  <= '0;
      spare_ref_q <= '0;
      main_chk    <= 1'b0;
      spare_chk   <= 1'b0;
    end else if (ecc_clear) begin
      main_chk  <= 1'b0;
      spare_chk <= 1'b0;
    end else begin
      if (main_ref_load) begin
        main_ref_q <= main_ref;
        main_chk   <= 1'b1;
      end
      if (spare_ref_load) begin
        spare_ref_q <= spare_ref;
        spare_chk   <= 1'b1;
      end
    end
  end

  ecc_syndrome #(.AW(MAIN_AW), .CW(MAIN_CW)) u_main_syn (
    .chk(main_chk), .syn(main_ref_q ^ main_code),
    .stat(main_stat), .loc_byte(main_err_byte), .loc_bit(main_err_bit)
  );

  ecc_syndrome #(.AW(SPARE_AW), .CW(SPARE_CW)) u_spare_syn (
    .chk(spare_chk), .syn(spare_ref_q ^ spare_code),
    .stat(spare_stat), .loc_byte(spare_err_byte), .loc_bit(spare_err_bit)
  );

  assign err_status = {spare_stat, main_stat};

endmodule

// File: rtl/nand_page_ecc_chk.sv
module nand_page_ecc_chk #(
  parameter int MAIN_AW  = 11,
  parameter int SPARE_AW = 2,
  parameter int MAIN_CW  = 32,
  parameter int SPARE_CW = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ecc_clear,
  input logic                main_lock,
  input logic                spare_lock,
  input logic [MAIN_CW-1:0]  main_code,
  input logic [SPARE_CW-1:0] spare_code,
  input logic [3:0]          err_status,
  input logic [MAIN_AW-1:0]  main_err_byte,
  input logic [2:0]          main_err_bit,
  input logic [SPARE_AW-1:0] spare_err_byte,
  input logic [2:0]          spare_err_bit
);

  AST_MAIN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    main_lock && $past(main_lock) && $past(main_lock, 2) |-> $stable(main_code)); // R4

  AST_SPARE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    spare_lock && $past(spare_lock) && $past(spare_lock, 2) |-> $stable(spare_code)); // R4

  AST_STATUS_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ecc_clear) |-> err_status == 4'b0000); // R7

  AST_MAIN_LOC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_status[1:0] != 2'b01 |-> (main_err_byte == '0 && main_err_bit == 3'd0)); // R8

  AST_SPARE_LOC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_status[3:2] != 2'b01 |-> (spare_err_byte == '0 && spare_err_bit == 3'd0)); // R8

endmodule

bind nand_page_ecc nand_page_ecc_chk #(
  .MAIN_AW(MAIN_AW), .SPARE_AW(SPARE_AW), .MAIN_CW(MAIN_CW), .SPARE_CW(SPARE_CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ecc_clear(ecc_clear), .main_lock(main_lock),
  .spare_lock(spare_lock), .main_code(main_code), .spare_code(spare_code),
  .err_status(err_status), .main_err_byte(main_err_byte), .main_err_bit(main_err_bit),
  .spare_err_byte(spare_err_byte), .spare_err_bit(spare_err_bit)
);

// File: tb/tb_nand_page_ecc.sv
`timescale 1ns/1ps
module tb_nand_page_ecc;

  localparam int NB = 64;   // main bytes, offset 6 bits, code 24 bits
  localparam int AW = 6;
  localparam int SB = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ecc_clear = 1'b0;
  logic        main_lock = 1'b1;
  logic        spare_lock = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic [23:0] main_code;
  logic [15:0] spare_code;
  logic        main_ref_load = 1'b0;
  logic [23:0] main_ref = '0;
  logic        spare_ref_load = 1'b0;
  logic [15:0] spare_ref = '0;
  logic [3:0]  err_status;
  logic [5:0]  main_err_byte;
  logic [2:0]  main_err_bit;
  logic [1:0]  spare_err_byte;
  logic [2:0]  spare_err_bit;

  always #2 clk = ~clk;

  nand_page_ecc #(.MAIN_BYTES(NB), .SPARE_BYTES(SB)) dut (
    .clk(clk), .rst_n(rst_n), .ecc_clear(ecc_clear), .main_lock(main_lock),
    .spare_lock(spare_lock), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .main_code(main_code), .spare_code(spare_code), .main_ref_load(main_ref_load),
    .main_ref(main_ref), .spare_ref_load(spare_ref_load), .spare_ref(spare_ref),
    .err_status(err_status), .main_err_byte(main_err_byte), .main_err_bit(main_err_bit),
    .spare_err_byte(spare_err_byte), .spare_err_bit(spare_err_bit)
  );

  int n_chk = 0;
  int n_err = 0;
  logic [7:0]  pg [64];
  logic [7:0]  rd [64];
  logic [7:0]  sflip [4];
  logic [23:0] mref_x;
  logic [31:0] st_main;
  logic [15:0] st_spare;

  task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // arithmetic model of the code layout in R5
  function automatic logic [31:0] calc(input int n, input int aw, input logic [7:0] b [64]);
    logic [31:0] c = '0;
    for (int i = 0; i < n; i++) begin
      for (int t = 0; t < 8; t++) begin
        if (b[i][t]) begin
          for (int k = 0; k < aw; k++) c[2*k + ((i >> k) & 1)] ^= 1'b1;
          for (int j = 0; j < 3; j++)  c[2*aw + 2*j + ((t >> j) & 1)] ^= 1'b1;
        end
      end
    end
    return c;
  endfunction

  function automatic logic [15:0] spare_of(input logic [31:0] m, input logic [7:0] f [4]);
    logic [7:0] s [64];
    for (int i = 0; i < 64; i++) s[i] = '0;
    for (int i = 0; i < 4; i++) s[i] = m[8*i +: 8] ^ f[i];
    return calc(SB, 2, s)[15:0];
  endfunction

  task automatic set_stored();
    logic [7:0] z [4];
    for (int i = 0; i < 4; i++) z[i] = '0;
    st_main  = calc(NB, AW, pg);
    st_spare = spare_of(st_main, z);
    rd = pg;
    for (int i = 0; i < 4; i++) sflip[i] = '0;
    mref_x = '0;
  endtask

  task automatic put_byte(input logic [7:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    @(posedge clk);
  endtask

  task automatic do_clear();
    @(negedge clk);
    in_valid = 1'b0; ecc_clear = 1'b1; main_lock = 1'b1; spare_lock = 1'b1;
    @(negedge clk);
    ecc_clear = 1'b0; main_lock = 1'b0;
  endtask

  task automatic spare_pass();
    @(negedge clk);
    spare_lock = 1'b0;
    for (int i = 0; i < 4; i++) put_byte(st_main[8*i +: 8] ^ sflip[i]);
    @(negedge clk);
    in_valid = 1'b0; spare_lock = 1'b1;
    @(negedge clk);
  endtask

  task automatic load_refs();
    @(negedge clk);
    main_ref_load = 1'b1; main_ref = st_main[23:0] ^ mref_x;
    spare_ref_load = 1'b1; spare_ref = st_spare;
    @(negedge clk);
    main_ref_load = 1'b0; spare_ref_load = 1'b0;
  endtask

  task automatic page_pass();
    do_clear();
    for (int i = 0; i < NB; i++) put_byte(rd[i]);
    @(negedge clk);
    in_valid = 1'b0; main_lock = 1'b1;
    spare_pass();
    load_refs();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R2 ready after reset", {31'd0, in_ready}, 32'd1);
    check_eq("R7 status after reset", {28'd0, err_status}, 32'd0);
    check_eq("R4 main code after reset", {8'd0, main_code}, 32'd0);

    // R2: back-pressure only during clear
    @(negedge clk);
    ecc_clear = 1'b1; in_valid = 1'b1;
    #1 check_eq("R2 ready low in clear", {31'd0, in_ready}, 32'd0);
    @(negedge clk);
    ecc_clear = 1'b0; in_valid = 1'b0;
    #1 check_eq("R2 ready back after clear", {31'd0, in_ready}, 32'd1);

    // R3 R5 R6 R7: several data patterns, clean read
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < NB; i++)
        case (p)
          0: pg[i] = 8'h00;
          1: pg[i] = 8'hFF;
          2: pg[i] = 8'(i);
          default: pg[i] = 8'(i * 37) ^ 8'h5A;
        endcase
      set_stored();
      page_pass();
      check_eq("R5 main code pattern", {8'd0, main_code}, st_main);
      check_eq("R6 spare code pattern", {16'd0, spare_code}, {16'd0, st_spare});
      check_eq("R7 clean status", {28'd0, err_status}, 32'd0);
    end

    // R8: exhaustive single-bit main errors
    for (int i = 0; i < NB; i++) begin
      for (int b = 0; b < 8; b++) begin
        rd = pg;
        rd[i][b] = ~rd[i][b];
        page_pass();
        check_eq("R8 main status 01", {28'd0, err_status}, 32'h1);
        check_eq("R8 main byte", {26'd0, main_err_byte}, 32'(i));
        check_eq("R8 main bit", {29'd0, main_err_bit}, 32'(b));
      end
    end
    rd = pg;

    // R1 R7: clear drops reported status
    rd[5][2] = ~rd[5][2];
    page_pass();
    check_eq("R1 status set before clear", {28'd0, err_status}, 32'h1);
    @(negedge clk); ecc_clear = 1'b1;
    @(negedge clk); ecc_clear = 1'b0;
    check_eq("R1 status zero after clear", {28'd0, err_status}, 32'd0);
    rd = pg;

    // R8: single-bit errors in spare-covered bytes
    for (int i = 0; i < SB; i++) begin
      for (int b = 0; b < 8; b++) begin
        for (int q = 0; q < 4; q++) sflip[q] = '0;
        sflip[i][b] = 1'b1;
        page_pass();
        check_eq("R8 spare status 01", {28'd0, err_status}, 32'h4);
        check_eq("R8 spare byte", {30'd0, spare_err_byte}, 32'(i));
        check_eq("R8 spare bit", {29'd0, spare_err_bit}, 32'(b));
      end
    end
    for (int q = 0; q < 4; q++) sflip[q] = '0;

    // R9: single flipped bit in the stored main code
    for (int c = 0; c < 24; c++) begin
      mref_x = 24'd1 << c;
      page_pass();
      check_eq("R9 code error 11", {28'd0, err_status}, 32'h3);
      check_eq("R8 no location on 11", {26'd0, main_err_byte}, 32'd0);
    end
    mref_x = '0;

    // R9: two data bits wrong
    rd[3][1] = ~rd[3][1];
    rd[10][6] = ~rd[10][6];
    page_pass();
    check_eq("R9 double error 10", {28'd0, err_status}, 32'h2);
    rd = pg;
    rd[7][0] = ~rd[7][0];
    rd[7][5] = ~rd[7][5];
    page_pass();
    check_eq("R9 same-byte double 10", {28'd0, err_status}, 32'h2);
    rd = pg;

    // R3 R4: bytes sent while locked are ignored, latch at lock rise
    begin
      logic [7:0] part [64];
      for (int i = 0; i < 64; i++) part[i] = (i < 20) ? pg[i] : 8'h00;
      do_clear();
      for (int i = 0; i < 20; i++) put_byte(pg[i]);
      @(negedge clk);
      in_valid = 1'b0; main_lock = 1'b1;
      for (int g = 0; g < 5; g++) put_byte(8'hA5 ^ 8'(g));
      @(negedge clk);
      check_eq("R4 latched partial code", {8'd0, main_code}, calc(20, AW, part));
      in_valid = 1'b0; main_lock = 1'b0;
      for (int i = 20; i < NB; i++) put_byte(pg[i]);
      @(negedge clk);
      in_valid = 1'b0; main_lock = 1'b1;
      @(negedge clk);
      check_eq("R3 locked bytes ignored", {8'd0, main_code}, st_main);
      for (int g = 0; g < 3; g++) put_byte(8'h3C);
      @(negedge clk);
      in_valid = 1'b0;
      check_eq("R4 code held while locked", {8'd0, main_code}, st_main);
    end

    // R6: bytes beyond the region size are ignored
    do_clear();
    for (int i = 0; i < NB + 6; i++) put_byte(i < NB ? pg[i] : 8'hC3);
    @(negedge clk);
    in_valid = 1'b0; main_lock = 1'b1;
    @(negedge clk);
    spare_lock = 1'b0;
    for (int i = 0; i < SB + 3; i++) put_byte(i < SB ? st_main[8*i +: 8] : 8'h96);
    @(negedge clk);
    in_valid = 1'b0; spare_lock = 1'b1;
    @(negedge clk);
    check_eq("R6 main saturates", {8'd0, main_code}, st_main);
    check_eq("R6 spare saturates", {16'd0, spare_code}, {16'd0, st_spare});

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule